// File: doc/BRIEF.md
# Interrupt Target Register Bank

This block holds the CPU target byte of every interrupt in a multiprocessor interrupt distributor. Software reaches it through a word-wide register port. Each 32-bit word covers four interrupts, one byte each. Each byte is a mask of the CPUs that an interrupt is routed to. The stored masks of the shared interrupts (number 32 and up) are driven out as a flat vector, so that downstream routing logic can use them.

The first 32 interrupts are private to each CPU, and they have no storage. What their target bytes return depends on two things: the `REVISION` parameter (legacy, or generation 2) and the processor count `NUM_CPU`. A private target byte either reads as zero, or reads as the one-hot mask of the CPU making the request. Writes to a private byte are always dropped.

Every request gets a registered response on the next cycle. A request to an interrupt number beyond `NUM_IRQ` is flagged as a bad access and has no effect.

Top module: `itb_bank`

## Requirements
- R1: Word index w, byte lane k (bits 8k+7..8k) addresses interrupt 4w+k. A write changes only the lanes whose bit in `req_be` is set.
- R2: For interrupts 32 and above, a read returns the stored byte, and a write with the lane enabled replaces it.
- R3: With `REVISION` legacy (0), the bytes of interrupts 0 to 28 read as zero.
- R4: With `REVISION` legacy, the bytes of interrupts 29 to 31 read as the requester's one-hot mask, with bit n set for `req_cpu` = n.
- R5: With `REVISION` generation 2 (1) and `NUM_CPU` = 1, the bytes of all interrupts below 32 read as zero.
- R6: With `REVISION` generation 2 and `NUM_CPU` > 1, the bytes of all interrupts below 32 read as the requester's one-hot mask. `req_cpu` is 3 bits wide, so CPU indices 0 to 7 are covered.
- R7: A write to an interrupt below 32 changes no stored state, under every configuration.
- R8: A request whose word covers interrupt numbers at or above `NUM_IRQ` sets `rsp_err`, returns zero data and changes no state.
- R9: Reset (synchronous, active low) clears every stored byte and produces no response.
- R10: Each accepted request produces `rsp_valid` on the next cycle, together with `rsp_rdata` and `rsp_err`. A write returns zero data, and a cycle with no request produces no response.
- R11: Byte j of `tgt_out` is the stored target of interrupt 32+j. It shows a write from the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | ADDR_W | Word index (four interrupts per word) |
| req_be | input | 4 | Byte-lane write enables |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 3 | Index of the requesting CPU |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Bad-register flag |
| tgt_out | output | (NUM_IRQ-32)*8 | Stored shared-interrupt targets |

## Verification
A read response is registered, while a write commits at the same edge. So the response to a read of a word can be on the port in the very cycle that a write to that word is accepted. The bench provokes this with a back-to-back read and write of one shared word, with no idle cycle between them. The read must return the old contents. The write response, a later read and `tgt_out` must all show the new contents.

// File: rtl/itb_pkg.sv
// Package: shared types and helpers for the interrupt target register bank.
// Assumes the private interrupt range is fixed at 32 interrupts.
package itb_pkg;

    typedef enum logic {
        REV_LEGACY = 1'b0,
        REV_GEN2   = 1'b1
    } rev_e;

    // What a byte lane of the current request maps to
    typedef enum logic [1:0] {
        LANE_ZERO   = 2'd0,
        LANE_CPU    = 2'd1,
        LANE_SHARED = 2'd2,
        LANE_BAD    = 2'd3
    } lane_e;

    localparam int PRIV_IRQS        = 32;
    localparam int LEGACY_CPU_FIRST = 29;

    // One-hot mask naming a CPU index
    function automatic logic [7:0] cpu_onehot(input logic [2:0] idx);
        return 8'd1 << idx;
    endfunction

endpackage

// File: rtl/itb_lane_decode.sv
// Module: itb_lane_decode
// Classifies each of the four byte lanes of a request word as zero-reading,
// CPU-mask-reading, shared storage, or out of range.
// Assumes NUM_IRQ is a multiple of 4 and NUM_IRQ/4 < 2**ADDR_W.
module itb_lane_decode
    import itb_pkg::*;
#(
    parameter int   NUM_IRQ  = 64,
    parameter int   NUM_CPU  = 4,
    parameter rev_e REVISION = REV_GEN2,
    parameter int   ADDR_W   = 8
) (
    input  logic [ADDR_W-1:0] req_word,
    output lane_e [3:0]       lane_cls,
    output logic              word_bad
);
    localparam int IRQ_W = ADDR_W + 2;
    localparam logic [ADDR_W-1:0] WORD_LIM = ADDR_W'(NUM_IRQ / 4);
    localparam logic [IRQ_W-1:0]  PRIV_L   = IRQ_W'(PRIV_IRQS);
    localparam logic [IRQ_W-1:0]  LEG_L    = IRQ_W'(LEGACY_CPU_FIRST);
    localparam bit                MULTI    = (NUM_CPU > 1);

    // Whole word beyond the configured interrupt count
    assign word_bad = (req_word >= WORD_LIM);

    for (genvar k = 0; k < 4; k++) begin : g_lane
        logic [IRQ_W-1:0] irq;
        assign irq = {req_word, 2'(k)};

        // Per-lane class from interrupt number, revision and CPU count
        always_comb begin
            if (word_bad) begin
                lane_cls[k] = LANE_BAD;
            end else if (irq >= PRIV_L) begin
                lane_cls[k] = LANE_SHARED;
            end else if (REVISION == REV_LEGACY) begin
                lane_cls[k] = (irq < LEG_L) ? LANE_ZERO : LANE_CPU;
            end else begin
                lane_cls[k] = MULTI ? LANE_CPU : LANE_ZERO;
            end
        end
    end

endmodule

// File: rtl/itb_store.sv
// Module: itb_store
// Holds the target bytes of the shared interrupts (32 and up). Byte j
// belongs to interrupt 32+j, i.e. word (32+j)/4, lane j%4.
// Assumes the caller gates lane_wr with the request and lane class.
module itb_store #(
    parameter int NUM_SHARED = 32,
    parameter int ADDR_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       word,
    input  logic [3:0]              lane_wr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rd_word,
    output logic [NUM_SHARED*8-1:0] tgt_flat
);
    localparam int PRIV = itb_pkg::PRIV_IRQS;

    logic [NUM_SHARED-1:0][7:0] tgt;

    // Byte-lane writes into the shared target bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt <= '0;
        end else begin
            for (int j = 0; j < NUM_SHARED; j++) begin
                if (word == ADDR_W'((j + PRIV) / 4) && lane_wr[j % 4]) begin
                    tgt[j] <= wdata[(j % 4) * 8 +: 8];
                end
            end
        end
    end

    // Combinational read of the addressed word
    always_comb begin
        rd_word = '0;
        for (int j = 0; j < NUM_SHARED; j++) begin
            if (word == ADDR_W'((j + PRIV) / 4)) begin
                rd_word[(j % 4) * 8 +: 8] = tgt[j];
            end
        end
    end

    assign tgt_flat = tgt;

    for (genvar j = 0; j < NUM_SHARED; j++) begin : g_hold
        localparam logic [ADDR_W-1:0] MY_WORD = ADDR_W'((j + PRIV) / 4);
        // R2: a byte changes only when its own word and lane are written
        assert_byte_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(word == MY_WORD && lane_wr[j % 4]) |=> $stable(tgt_flat[j*8 +: 8]));
    end

endmodule

// File: rtl/itb_rsp.sv
// Module: itb_rsp
// Registers the response of each request: valid, read data and error flag,
// all one cycle after the request. Writes and bad accesses return zero.
module itb_rsp (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        word_bad,
    input  logic [31:0] lane_data,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err
);
    // Response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && word_bad;
            rsp_rdata <= (req_valid && !req_write && !word_bad) ? lane_data : '0;
        end
    end

    assert_rsp_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && word_bad) |=> (rsp_err && rsp_rdata == '0));
    assert_write_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));

endmodule

// File: rtl/itb_bank.sv
// Module: itb_bank (top)
// Per-interrupt CPU target register bank. Decodes each byte lane of a word
// request, answers private lanes as zero or the requester's CPU mask, stores
// shared lanes, and registers the response. Assumes NUM_IRQ is a multiple
// of 4, at least 36, and NUM_IRQ/4 < 2**ADDR_W.
module itb_bank
    import itb_pkg::*;
#(
    parameter int   NUM_IRQ  = 64,
    parameter int   NUM_CPU  = 4,
    parameter rev_e REVISION = REV_GEN2,
    parameter int   ADDR_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_word,
    input  logic [3:0]                    req_be,
    input  logic [31:0]                   req_wdata,
    input  logic [2:0]                    req_cpu,
    output logic                          rsp_valid,
    output logic [31:0]                   rsp_rdata,
    output logic                          rsp_err,
    output logic [(NUM_IRQ-32)*8-1:0]     tgt_out
);
    localparam int NUM_SHARED = NUM_IRQ - PRIV_IRQS;
    localparam logic [ADDR_W-1:0] PRIV_WORDS = ADDR_W'(PRIV_IRQS / 4);

    lane_e [3:0] lane_cls;
    logic        word_bad;
    logic [3:0]  lane_wr;
    logic [31:0] store_rd;
    logic [31:0] lane_data;

    itb_lane_decode #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_CPU (NUM_CPU),
        .REVISION(REVISION),
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .req_word(req_word),
        .lane_cls(lane_cls),
        .word_bad(word_bad)
    );

    // Lane write strobes: only enabled shared lanes of a valid write
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            lane_wr[k] = req_valid && req_write && req_be[k] && (lane_cls[k] == LANE_SHARED);
        end
    end

    itb_store #(
        .NUM_SHARED(NUM_SHARED),
        .ADDR_W    (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .word    (req_word),
        .lane_wr (lane_wr),
        .wdata   (req_wdata),
        .rd_word (store_rd),
        .tgt_flat(tgt_out)
    );

    // Read value of each lane by its class
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            case (lane_cls[k])
                LANE_CPU:    lane_data[k*8 +: 8] = cpu_onehot(req_cpu);
                LANE_SHARED: lane_data[k*8 +: 8] = store_rd[k*8 +: 8];
                default:     lane_data[k*8 +: 8] = 8'h00;
            endcase
        end
    end

    itb_rsp u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .word_bad (word_bad),
        .lane_data(lane_data),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .rsp_err  (rsp_err)
    );

    // R7: writes to private words leave all stored targets untouched
    assert_priv_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_word < PRIV_WORDS) |=> $stable(tgt_out));
    // R8: out-of-range requests leave all stored targets untouched
    assert_bad_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && word_bad) |=> $stable(tgt_out));
    // R9: reset clears storage and response
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (tgt_out == '0 && !rsp_valid));
    // R6: a CPU-mask lane returns exactly one set bit
    assert_cpu_mask_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && lane_cls[3] == LANE_CPU) |=> $onehot(rsp_rdata[31:24]));
    // R3: a zero lane returns zero
    assert_zero_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && lane_cls[0] == LANE_ZERO) |=> (rsp_rdata[7:0] == 8'h00));

endmodule

// File: tb/tb_itb_bank.sv
`timescale 1ns/1ps
module tb_itb_bank;
    import itb_pkg::*;

    localparam int NV = 15;
    localparam int TW = (64 - 32) * 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_word = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [2:0]  req_cpu = '0;

    logic        rv [3];
    logic [31:0] rd [3];
    logic        re [3];
    logic [TW-1:0] tg [3];

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    // dut: generation 2, 4 CPUs; dut_leg: legacy; dut_up: generation 2, 1 CPU
    itb_bank #(.NUM_IRQ(64), .NUM_CPU(4), .REVISION(REV_GEN2), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_be(req_be), .req_wdata(req_wdata), .req_cpu(req_cpu),
        .rsp_valid(rv[0]), .rsp_rdata(rd[0]), .rsp_err(re[0]), .tgt_out(tg[0]));
    itb_bank #(.NUM_IRQ(64), .NUM_CPU(4), .REVISION(REV_LEGACY), .ADDR_W(8)) dut_leg (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_be(req_be), .req_wdata(req_wdata), .req_cpu(req_cpu),
        .rsp_valid(rv[1]), .rsp_rdata(rd[1]), .rsp_err(re[1]), .tgt_out(tg[1]));
    itb_bank #(.NUM_IRQ(64), .NUM_CPU(1), .REVISION(REV_GEN2), .ADDR_W(8)) dut_up (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_be(req_be), .req_wdata(req_wdata), .req_cpu(req_cpu),
        .rsp_valid(rv[2]), .rsp_rdata(rd[2]), .rsp_err(re[2]), .tgt_out(tg[2]));

    // {write, word, be, wdata, cpu, expected rdata, expected err} for dut
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, 8'd8,  4'hF,    32'h0,        3'd0, 32'h0,        1'b0}, // R9 reset value
        {1'b1, 8'd8,  4'hF,    32'h08040201, 3'd0, 32'h0,        1'b0}, // R10 write returns 0
        {1'b0, 8'd8,  4'hF,    32'h0,        3'd1, 32'h08040201, 1'b0}, // R2
        {1'b1, 8'd9,  4'b0101, 32'hAABBCCDD, 3'd0, 32'h0,        1'b0}, // R1 partial
        {1'b0, 8'd9,  4'hF,    32'h0,        3'd0, 32'h00BB00DD, 1'b0}, // R1
        {1'b0, 8'd3,  4'hF,    32'h0,        3'd2, 32'h04040404, 1'b0}, // R6
        {1'b0, 8'd7,  4'hF,    32'h0,        3'd3, 32'h08080808, 1'b0}, // R6
        {1'b1, 8'd2,  4'hF,    32'hFFFFFFFF, 3'd0, 32'h0,        1'b0}, // R7
        {1'b0, 8'd2,  4'hF,    32'h0,        3'd0, 32'h01010101, 1'b0}, // R7
        {1'b0, 8'd16, 4'hF,    32'h0,        3'd0, 32'h0,        1'b1}, // R8
        {1'b1, 8'd16, 4'hF,    32'hFFFFFFFF, 3'd0, 32'h0,        1'b1}, // R8
        {1'b0, 8'd8,  4'hF,    32'h0,        3'd0, 32'h08040201, 1'b0}, // R8 no change
        {1'b0, 8'd15, 4'hF,    32'h0,        3'd0, 32'h0,        1'b0}, // R2
        {1'b1, 8'd15, 4'b1000, 32'h5A000000, 3'd0, 32'h0,        1'b0}, // R1
        {1'b0, 8'd15, 4'hF,    32'h0,        3'd0, 32'h5A000000, 1'b0}  // R1 top lane
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request with an idle cycle after; response sampled at next negedge
    task automatic acc(input logic wr, input logic [7:0] w, input logic [3:0] be,
                       input logic [31:0] d, input logic [2:0] cpu);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = w;
        req_be = be; req_wdata = d; req_cpu = cpu;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Reset state (R9)
        repeat (3) @(negedge clk);
        chk("R9 tgt_out after reset", 32'(tg[0] != '0), 32'd0);
        chk("R9 no response in reset", {31'd0, rv[0]}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle gives no response", {31'd0, rv[0]}, 32'd0);

        // Vector table on the generation-2 multiprocessor instance
        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][80], VEC[i][79:72], VEC[i][71:68], VEC[i][67:36], VEC[i][35:33]);
            chk($sformatf("R10 valid row %0d", i), {31'd0, rv[0]}, 32'd1);
            chk($sformatf("R1 R2 R6 R7 R8 data row %0d", i), rd[0], VEC[i][32:1]);
            chk($sformatf("R8 err row %0d", i), {31'd0, re[0]}, {31'd0, VEC[i][0]});
        end

        // Shared targets on the output vector (R11)
        chk("R11 irq32..35", tg[0][31:0], 32'h08040201);
        chk("R11 irq36..39", tg[0][63:32], 32'h00BB00DD);
        chk("R11 irq63", {24'd0, tg[0][255:248]}, 32'h5A);
        chk("R7 legacy storage untouched by private write", tg[1][31:0], 32'h08040201);

        // Legacy revision private lanes
        acc(1'b0, 8'd7, 4'hF, 32'h0, 3'd2);
        chk("R3 R4 legacy word 7 cpu2", rd[1], 32'h04040400);
        acc(1'b0, 8'd0, 4'hF, 32'h0, 3'd5);
        chk("R3 legacy word 0", rd[1], 32'h0);
        chk("R6 cpu index 5 mask", rd[0], 32'h20202020);
        // Uniprocessor generation 2
        chk("R5 uniprocessor word 0", rd[2], 32'h0);
        acc(1'b0, 8'd7, 4'hF, 32'h0, 3'd0);
        chk("R5 uniprocessor word 7", rd[2], 32'h0);
        acc(1'b1, 8'd7, 4'hF, 32'hFFFFFFFF, 3'd0);
        acc(1'b0, 8'd7, 4'hF, 32'h0, 3'd0);
        chk("R7 legacy word 7 after write", rd[1], 32'h01010100);
        chk("R7 uniprocessor word 7 after write", rd[2], 32'h0);

        // Back-to-back read then write of one shared word
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_word = 8'd10; req_be = 4'hF; req_cpu = 3'd0;
        @(negedge clk);
        chk("R10 read response beside write", rd[0], 32'h0);
        req_write = 1'b1; req_wdata = 32'h11223344;
        @(negedge clk);
        chk("R10 write response", rd[0], 32'h0);
        chk("R11 irq40 updated", {24'd0, tg[0][71:64]}, 32'h44);
        req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 read after back-to-back write", rd[0], 32'h11223344);

        // Mid-run reset clears storage (R9)
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 mid-run reset clears", 32'(tg[0] != '0), 32'd0);
        rst_n = 1'b1;
        acc(1'b0, 8'd8, 4'hF, 32'h0, 3'd0);
        chk("R9 read after reset", rd[0], 32'h0);

        finish_run();
    end

endmodule